// File: doc/BRIEF.md
# Interrupt Cause and Enable Register Block

This block collects the event pulses of a memory-mapped-to-serial-link bridge into sticky cause bits. Each cause bit can be enabled by a matching bit in an enable register. The enabled causes are merged into one interrupt line. Software reaches the three registers through an AXI4-Lite slave port. It reads the cause register to find the reason for an interrupt, then writes ones to the bits it has handled.

Three of the cause bits record received error messages: correctable, non-fatal and fatal. A write-one alone does not clear them. The companion error queue must first be drained by a read followed by a writeback of the same value, and the queue reports this on `efifo_wb_done`. That pulse arms exactly one clearing write.

A control register holds three bits:
- a global interrupt disable, which gates only the line;
- an override that turns write-one-to-clear into plain writes;
- a stored bit that permits writes to read-only fields elsewhere.

Register offsets (byte addresses, word aligned): control 0x134, cause 0x138, enable 0x13C.

Top module: `irq_decode_regs`

## Requirements
- R1: A one-cycle pulse on `event_in[n]` sets cause bit n, and the bit stays set until software clears it. The implemented cause bits are 1, 2, 3, 5, 6, 7, 8, 9, 10, 11, 16, 17, 20, 21, 22 and 23 (bit 0 is described in R6).
- R2: Cause bits 4, 12 to 15, 18, 19 and 24 to 31 never set and always read zero. `event_in[0]` is ignored.
- R3: When control bit 16 is clear, writing 1 to a cause bit outside 9 to 11 clears that bit. Writing 0 leaves it unchanged.
- R4: Cause bits 9, 10 and 11 ignore a write-one-to-clear unless an `efifo_wb_done` pulse has armed them. The arm is spent by the first such write that targets any of these three bits, and it is withdrawn by any new event on them.
- R5: The enable register at 0x13C uses the same bit positions as the cause register; its unimplemented bits read zero. `irq_o` is high exactly when (cause AND enable) is nonzero and the global disable is clear. `irq_o` is registered: it follows the register state one clock later.
- R6: Cause bit 0 sets on a falling edge of `link_up`. It does not set while the link stays down, and it does not set on a rising edge.
- R7: Control bit 8 (global disable) holds `irq_o` low. Cause bits still latch while it is set.
- R8: When control bit 16 is set, a write to the cause register stores the written value directly into the strobed bytes, and bits 9 to 11 are included.
- R9: Control bits 8, 16 and 17 are read/write. All other control bits read zero.
- R10: After reset, the control, cause and enable registers read zero and `irq_o` is low.
- R11: If an event and a clearing write hit the same cause bit in the same cycle, the bit stays set.
- R12: A write changes only the bytes whose `s_wstrb` bit is 1 (`s_wstrb[k]` covers data bits 8k+7 to 8k).
- R13: Every response is OKAY (`00`). Reads of unmapped offsets return zero, and writes to unmapped offsets change nothing. `s_bvalid` and `s_rvalid` stay high until their ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link-up level, sampled for the link-down cause |
| event_in | input | 32 | One-cycle event pulses, one per cause bit |
| efifo_wb_done | input | 1 | Error queue drained by read-then-writeback; arms clearing of bits 9 to 11 |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions check several rules on every cycle:
- cause bits fall only on a write, and bits 9 to 11 never fall on an unarmed clearing write;
- an event pulse always leaves its bit set, even under a concurrent clear;
- the link-down bit does not move while the link stays down;
- the global disable forces the line low;
- the response channels hold their valid signals.

Only the bench scenarios can show the rest: the exact values read back after chains of events and writes, the one-shot nature of the arm, byte-strobe merging, the override mode, and the line rising and falling as enable bits change.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int REG_W  = 32;
  localparam int STRB_W = REG_W / 8;

  localparam logic [REG_W-1:0] CAUSE_IMPL  = 32'h00F3_0FEF;
  localparam logic [REG_W-1:0] ERRMSG_BITS = 32'h0000_0E00;
  localparam logic [REG_W-1:0] CTRL_IMPL   = 32'h0003_0100;

  localparam int CTRL_GDIS   = 8;
  localparam int CTRL_PLAIN  = 16;
  localparam int CTRL_ROWR   = 17;
  localparam int LINKDN_BIT  = 0;

  localparam logic [31:0] OFS_CTRL  = 32'h0000_0134;
  localparam logic [31:0] OFS_CAUSE = 32'h0000_0138;
  localparam logic [31:0] OFS_EN    = 32'h0000_013C;

  // Expand byte strobes into a bit mask.
  function automatic logic [REG_W-1:0] strb_to_mask(input logic [STRB_W-1:0] s);
    logic [REG_W-1:0] m;
    for (int b = 0; b < STRB_W; b++) m[8*b +: 8] = {8{s[b]}};
    return m;
  endfunction

  // Sticky update with a clear vector; a set always wins.
  function automatic logic [REG_W-1:0] w1c_next(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] set,
                                                input logic [REG_W-1:0] clr);
    return set | (cur & ~clr);
  endfunction

  // Plain store into strobed bits; a set still wins.
  function automatic logic [REG_W-1:0] plain_next(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] set,
                                                  input logic [REG_W-1:0] wd,
                                                  input logic [REG_W-1:0] bm);
    return set | (wd & bm) | (cur & ~bm);
  endfunction
endpackage

// File: rtl/irq_axil_port.sv
module irq_axil_port
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [REG_W-1:0]  s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [REG_W-1:0]  s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic [STRB_W-1:0] wr_strb,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]  rd_word
);
  logic             bvalid_q, rvalid_q, rd_fire;
  logic [REG_W-1:0] rdata_q;

  // Address and data are taken together, one write in flight.
  assign wr_fire   = s_awvalid & s_wvalid & ~bvalid_q;
  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign wr_addr   = s_awaddr;
  assign wr_data   = s_wdata;
  assign wr_strb   = s_wstrb;

  assign rd_fire   = s_arvalid & ~rvalid_q;
  assign s_arready = ~rvalid_q;
  assign rd_addr   = s_araddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_fire)       bvalid_q <= 1'b1;
      else if (s_bready) bvalid_q <= 1'b0;
      if (rd_fire) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_word;
      end else if (s_rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign s_bvalid = bvalid_q;
  assign s_bresp  = 2'b00;
  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;
  assign s_rresp  = 2'b00;

  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid); // R13
  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R13
endmodule

// File: rtl/irq_cause_bits.sv
module irq_cause_bits
  import irq_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic             wr_en,
  input  logic             plain_mode,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_bmask,
  input  logic             drain_ack,
  output logic [REG_W-1:0] cause_q
);
  logic             armed_q;
  logic [REG_W-1:0] clr_req, err_gate, nxt;
  logic             err_touch, err_evt;

  assign clr_req   = wr_data & wr_bmask & CAUSE_IMPL;
  assign err_gate  = armed_q ? '1 : ~ERRMSG_BITS;
  assign err_touch = wr_en & ~plain_mode & (|(clr_req & ERRMSG_BITS));
  assign err_evt   = |(set_vec & ERRMSG_BITS);

  always_comb begin
    if (!wr_en)          nxt = cause_q | set_vec;
    else if (plain_mode) nxt = plain_next(cause_q, set_vec, wr_data, wr_bmask);
    else                 nxt = w1c_next(cause_q, set_vec, clr_req & err_gate);
    nxt = nxt & CAUSE_IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      armed_q <= 1'b0;
    end else begin
      cause_q <= nxt;
      if (drain_ack)                 armed_q <= 1'b1;
      else if (err_touch || err_evt) armed_q <= 1'b0;
    end
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(cause_q) & ~cause_q) == '0)); // R1
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec))); // R11
  AST_ERR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !plain_mode && !armed_q) |=>
      ((($past(cause_q) & ~cause_q) & ERRMSG_BITS) == '0)); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~CAUSE_IMPL) == '0); // R2
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] cause,
  input  logic [REG_W-1:0] enable,
  input  logic             gdis,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (|(cause & enable)) & ~gdis;
  end

  assign irq_o = irq_q;

  AST_GDIS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    gdis |=> !irq_o); // R7
endmodule

// File: rtl/irq_decode_regs.sv
module irq_decode_regs
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic [31:0]       event_in,
  input  logic              efifo_wb_done,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              irq_o
);
  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [REG_W-1:0]  wr_data, rd_word, wr_bmask;
  logic [STRB_W-1:0] wr_strb;
  logic [31:0]       wa32, ra32;
  logic              sel_ctrl, sel_cause, sel_en, cause_wr_en;
  logic [REG_W-1:0]  ctrl_q, en_q, cause_q, set_vec;
  logic              link_up_q, link_fall;

  irq_axil_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  assign wa32      = 32'(wr_addr);
  assign ra32      = 32'(rd_addr);
  assign sel_ctrl  = wr_fire && (wa32 == OFS_CTRL);
  assign sel_cause = wr_fire && (wa32 == OFS_CAUSE);
  assign sel_en    = wr_fire && (wa32 == OFS_EN);
  assign cause_wr_en = sel_cause;
  assign wr_bmask  = strb_to_mask(wr_strb);

  // Link-down event: falling edge of the sampled link-up level.
  always_ff @(posedge clk) begin
    if (!rst_n) link_up_q <= 1'b0;
    else        link_up_q <= link_up;
  end
  assign link_fall = link_up_q & ~link_up;

  always_comb begin
    set_vec = event_in & CAUSE_IMPL;
    set_vec[LINKDN_BIT] = link_fall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
    end else begin
      if (sel_ctrl) ctrl_q <= ((ctrl_q & ~wr_bmask) | (wr_data & wr_bmask)) & CTRL_IMPL;
      if (sel_en)   en_q   <= ((en_q & ~wr_bmask) | (wr_data & wr_bmask)) & CAUSE_IMPL;
    end
  end

  irq_cause_bits u_cause (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_en(cause_wr_en),
    .plain_mode(ctrl_q[CTRL_PLAIN]), .wr_data(wr_data), .wr_bmask(wr_bmask),
    .drain_ack(efifo_wb_done), .cause_q(cause_q)
  );

  irq_line u_line (
    .clk(clk), .rst_n(rst_n), .cause(cause_q), .enable(en_q),
    .gdis(ctrl_q[CTRL_GDIS]), .irq_o(irq_o)
  );

  always_comb begin
    if (ra32 == OFS_CTRL)       rd_word = ctrl_q;
    else if (ra32 == OFS_CAUSE) rd_word = cause_q;
    else if (ra32 == OFS_EN)    rd_word = en_q;
    else                        rd_word = '0;
  end

  AST_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && !link_up_q && !cause_wr_en) |=> (cause_q[LINKDN_BIT] == $past(cause_q[LINKDN_BIT]))); // R6
endmodule

// File: tb/tb_irq_decode_regs.sv
module tb_irq_decode_regs;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_CTRL = 12'h134, A_CAUSE = 12'h138, A_EN = 12'h13C, A_NONE = 12'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0;
  logic [31:0] event_in = '0;
  logic efifo_wb_done = 1'b0;
  logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b0, s_arvalid = 1'b0, s_rready = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [3:0] s_wstrb = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid, irq_o;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irq_decode_regs #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .event_in(event_in),
    .efifo_wb_done(efifo_wb_done),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read value when read data is handed over.
  always @(negedge clk) begin
    if (s_rvalid && s_rready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R13 unexpected read act=%h exp=none", s_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(s_rdata, e, t);
        chk({30'd0, s_rresp}, 32'd0, "R13 rresp");
      end
    end
  end

  task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d,
                           input logic [3:0] st, input logic [31:0] ev);
    @(negedge clk);
    s_awaddr = a; s_awvalid = 1'b1; s_wdata = d; s_wstrb = st; s_wvalid = 1'b1; event_in = ev;
    @(posedge clk); #1;
    s_awvalid = 1'b0; s_wvalid = 1'b0; event_in = '0; s_bready = 1'b1;
    @(negedge clk);
    chk({29'd0, s_bvalid, s_bresp}, 32'd4, "R13 bvalid/bresp");
    @(posedge clk); #1;
    s_bready = 1'b0;
  endtask

  task automatic axi_read(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    @(posedge clk); #1;
    s_arvalid = 1'b0; s_rready = 1'b1;
    @(negedge clk);
    @(posedge clk); #1;
    s_rready = 1'b0;
  endtask

  task automatic pulse_evt(input logic [31:0] v);
    @(negedge clk); event_in = v;
    @(negedge clk); event_in = '0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); efifo_wb_done = 1'b1;
    @(negedge clk); efifo_wb_done = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk); @(negedge clk);
    chk({31'd0, irq_o}, {31'd0, e}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk({31'd0, irq_o}, 32'd0, "R10 irq after reset");
    axi_read(A_CAUSE, 32'h0, "R10 cause reset");
    axi_read(A_EN,    32'h0, "R10 enable reset");
    axi_read(A_CTRL,  32'h0, "R10 ctrl reset");

    // R1 latching
    pulse_evt(32'h0011_0006);
    axi_read(A_CAUSE, 32'h0011_0006, "R1 events latched");
    // R2 reserved positions and event_in[0] ignored
    pulse_evt(32'h0000_1011);
    axi_read(A_CAUSE, 32'h0011_0006, "R2 reserved ignored");
    // R13 unmapped
    axi_read(A_NONE, 32'h0, "R13 unmapped read");
    axi_write(A_NONE, 32'hFFFF_FFFF, 4'hF, '0);
    axi_read(A_CAUSE, 32'h0011_0006, "R13 unmapped write no effect");

    // R5 enable
    chk_irq(1'b0, "R5 irq with enable zero");
    axi_write(A_EN, 32'h0000_0004, 4'hF, '0);
    chk_irq(1'b1, "R5 irq enabled cause");
    axi_read(A_EN, 32'h0000_0004, "R5 enable readback");
    axi_write(A_EN, 32'hFFFF_FFFF, 4'hF, '0);
    axi_read(A_EN, 32'h00F3_0FEF, "R5 enable reserved zero");
    axi_write(A_EN, 32'h0000_0004, 4'hF, '0);

    // R3 W1C
    axi_write(A_CAUSE, 32'h0000_0006, 4'hF, '0);
    axi_read(A_CAUSE, 32'h0011_0000, "R3 w1c clears");
    chk_irq(1'b0, "R3 irq drops after clear");

    // R6 link down
    @(negedge clk); link_up = 1'b1;
    repeat (3) @(negedge clk);
    axi_read(A_CAUSE, 32'h0011_0000, "R6 rising edge no set");
    @(negedge clk); link_up = 1'b0;
    axi_read(A_CAUSE, 32'h0011_0001, "R6 falling edge sets");
    axi_write(A_CAUSE, 32'h0000_0001, 4'hF, '0);
    repeat (4) @(negedge clk);
    axi_read(A_CAUSE, 32'h0011_0000, "R6 stays clear while down");

    // R4 error message bits
    pulse_evt(32'h0000_0E00);
    axi_read(A_CAUSE, 32'h0011_0E00, "R1 error bits latch");
    axi_write(A_CAUSE, 32'h0000_0E00, 4'hF, '0);
    axi_read(A_CAUSE, 32'h0011_0E00, "R4 unarmed clear ignored");
    pulse_ack();
    axi_write(A_CAUSE, 32'h0000_0200, 4'hF, '0);
    axi_read(A_CAUSE, 32'h0011_0C00, "R4 armed clear");
    axi_write(A_CAUSE, 32'h0000_0400, 4'hF, '0);
    axi_read(A_CAUSE, 32'h0011_0C00, "R4 arm spent");
    pulse_ack();
    pulse_evt(32'h0000_0800);
    axi_write(A_CAUSE, 32'h0000_0C00, 4'hF, '0);
    axi_read(A_CAUSE, 32'h0011_0C00, "R4 new event disarms");
    pulse_ack();
    axi_write(A_CAUSE, 32'h0000_0C00, 4'hF, '0);
    axi_read(A_CAUSE, 32'h0011_0000, "R4 rearmed clear");

    // R7 global disable
    axi_write(A_EN, 32'hFFFF_FFFF, 4'hF, '0);
    chk_irq(1'b1, "R5 irq all enabled");
    axi_write(A_CTRL, 32'h0000_0100, 4'hF, '0);
    chk_irq(1'b0, "R7 disable holds low");
    pulse_evt(32'h0020_0000);
    axi_read(A_CAUSE, 32'h0031_0000, "R7 latch while disabled");
    chk_irq(1'b0, "R7 still low");
    axi_write(A_CTRL, 32'h0000_0000, 4'hF, '0);
    chk_irq(1'b1, "R7 re-enabled");

    // R9 control field
    axi_write(A_CTRL, 32'hFFFF_FFFF, 4'hF, '0);
    axi_read(A_CTRL, 32'h0003_0100, "R9 control readback");

    // R8 override
    axi_write(A_CTRL, 32'h0001_0000, 4'hF, '0);
    axi_write(A_CAUSE, 32'h0000_0A08, 4'hF, '0);
    axi_read(A_CAUSE, 32'h0000_0A08, "R8 plain write");
    axi_write(A_CTRL, 32'h0000_0000, 4'hF, '0);

    // R11 event vs clear
    axi_write(A_CAUSE, 32'h0000_0008, 4'hF, 32'h0000_0008);
    axi_read(A_CAUSE, 32'h0000_0A08, "R11 event wins");
    axi_write(A_CAUSE, 32'h0000_0008, 4'hF, '0);
    axi_read(A_CAUSE, 32'h0000_0A00, "R3 clear after collision");

    // R12 strobes
    pulse_evt(32'h00F3_0000);
    pulse_ack();
    axi_write(A_CAUSE, 32'hFFFF_FFFF, 4'b1011, '0);
    axi_read(A_CAUSE, 32'h00F3_0000, "R12 unstrobed byte kept");
    axi_write(A_CAUSE, 32'hFFFF_FFFF, 4'b0100, '0);
    axi_read(A_CAUSE, 32'h0000_0000, "R12 strobed byte cleared");

    // R13 bvalid held until bready
    @(negedge clk);
    s_awaddr = A_EN; s_awvalid = 1'b1; s_wdata = 32'h0; s_wstrb = 4'hF; s_wvalid = 1'b1;
    @(posedge clk); #1;
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    @(negedge clk); chk({31'd0, s_bvalid}, 32'd1, "R13 bvalid hold 1");
    @(negedge clk); chk({31'd0, s_bvalid}, 32'd1, "R13 bvalid hold 2");
    s_bready = 1'b1;
    @(posedge clk); #1; s_bready = 1'b0;
    @(negedge clk); chk({31'd0, s_bvalid}, 32'd0, "R13 bvalid released");
    axi_read(A_EN, 32'h0, "R13 enable written");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 32'd0, "R13 all reads answered");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule